// File: doc/BRIEF.md
# Segment Address Translation Unit

This unit converts a segment-relative offset into a 32-bit linear address. It keeps six segment registers. Each one holds a 16-bit selector and a cached copy of its descriptor: a base linear address, a limit, and permission bits. A load port writes a selector and its descriptor fields into one register in a single cycle. Fetching descriptors from memory tables is done elsewhere.

For each access request the unit chooses a segment register. An explicit override picks the register directly. Without an override, the access kind picks a default. The unit then checks the access against the segment limit and the segment permissions. One cycle after the request it presents either the translated address or a fault, together with the fields decoded from the selector of the register it used. A register with base 0 and a limit of 0xFFFFFFFF gives flat, identity translation.

Top module: `seg_xlat_unit`

## Requirements
- R1: After reset each of the six registers holds selector 0, base 0, limit 0xFFFFFFFF and all permissions set. Both rsp_valid and rsp_fault are low, so an access at offset X translates to X.
- R2: Without an override the segment is chosen from req_kind. Kind 2 (fetch) uses segment 0 (code). Kinds 3 (push) and 4 (pop) use segment 2 (stack). Kinds 0 (load), 1 (store) and 5 to 7 use segment 1 (data). Segment numbering is 0 code, 1 data, 2 stack, 3 to 5 extra.
- R3: With req_ovr_en high and req_ovr_seg in 0 to 5, that segment is used. Override values 6 and 7 are ignored, and the default from R2 applies.
- R4: A cycle with ld_en high and ld_idx in 0 to 5 writes that register's selector, base, limit and permissions. A ld_idx of 6 or 7 changes no register.
- R5: rsp_addr equals base plus offset, taken modulo 2^32.
- R6: rsp_index, rsp_ti and rsp_rpl carry bits 15:3, bit 2 and bits 1:0 of the selector of the segment used.
- R7: With req_size giving the byte count minus 1 (0 to 3), a limit fault occurs when offset + req_size exceeds the limit. This sum is computed without wrap.
- R8: Permission bits are [2] execute, [1] read, [0] write. A protection fault occurs when a store or push targets a segment without write permission, or when a fetch targets a segment without execute permission.
- R9: rsp_fault_code bit 0 flags a limit fault and bit 1 flags a protection fault; both may be set together. Any fault drives rsp_fault high and keeps rsp_valid low. A clean access drives rsp_valid high with a code of 0.
- R10: Every cycle with req_valid high produces exactly one response one cycle later. A cycle without a request produces none.
- R11: A request in the same cycle as a load of its segment uses the register contents from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write one segment register |
| ld_idx | input | 3 | Segment register to write |
| ld_selector | input | 16 | Selector value |
| ld_base | input | 32 | Descriptor base |
| ld_limit | input | 32 | Descriptor limit (last valid offset) |
| ld_perm | input | 3 | Permissions: execute, read, write |
| req_valid | input | 1 | Access request |
| req_kind | input | 3 | Access kind code |
| req_ovr_en | input | 1 | Use explicit segment override |
| req_ovr_seg | input | 3 | Override segment number |
| req_offset | input | 32 | Segment-relative offset |
| req_size | input | 2 | Access bytes minus 1 |
| rsp_valid | output | 1 | Translated address valid |
| rsp_fault | output | 1 | Access faulted |
| rsp_fault_code | output | 2 | Fault cause: bit 1 protection, bit 0 limit |
| rsp_addr | output | 32 | Linear address |
| rsp_seg | output | 3 | Segment used |
| rsp_index | output | 13 | Selector table index |
| rsp_ti | output | 1 | Selector table indicator |
| rsp_rpl | output | 2 | Selector requestor privilege |

## Verification
The hardest cases to reach are the limit boundary and the limit sum that passes 2^32. The stimulus loads a segment with a limit of 3 and walks 4-byte accesses across its last offset. It then sends a 4-byte access at offset 0xFFFFFFFF to a full-size segment, which must fault even though the truncated sum would pass. A load and a request to the same segment are also placed in one cycle to show that the request sees the old contents. A read-only extra segment with a small limit produces a combined limit and protection fault.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  localparam int SEL_W   = 16;
  localparam int IDX_W   = 13;
  localparam int SEGN_W  = 3;
  localparam int PERM_W  = 3;

  localparam int PERM_X = 2;
  localparam int PERM_R = 1;
  localparam int PERM_W_BIT = 0;

  localparam int FLT_LIMIT = 0;
  localparam int FLT_PROT  = 1;

  typedef enum logic [2:0] {
    KIND_LOAD  = 3'd0,
    KIND_STORE = 3'd1,
    KIND_FETCH = 3'd2,
    KIND_PUSH  = 3'd3,
    KIND_POP   = 3'd4
  } acc_kind_e;

  localparam logic [SEGN_W-1:0] SEG_CODE  = 3'd0;
  localparam logic [SEGN_W-1:0] SEG_DATA  = 3'd1;
  localparam logic [SEGN_W-1:0] SEG_STACK = 3'd2;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_xlat_pkg::*;
#(
  parameter int NSEG = 6,
  parameter int AW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEGN_W-1:0] wr_idx,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [AW-1:0]     wr_base,
  input  logic [AW-1:0]     wr_limit,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [SEGN_W-1:0] rd_idx,
  output logic [SEL_W-1:0]  rd_sel,
  output logic [AW-1:0]     rd_base,
  output logic [AW-1:0]     rd_limit,
  output logic [PERM_W-1:0] rd_perm
);
  logic [SEL_W-1:0]  sel_q   [NSEG];
  logic [AW-1:0]     base_q  [NSEG];
  logic [AW-1:0]     limit_q [NSEG];
  logic [PERM_W-1:0] perm_q  [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic we;
    assign we = wr_en && (wr_idx == SEGN_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[i]   <= '0;
        base_q[i]  <= '0;
        limit_q[i] <= '1;
        perm_q[i]  <= '1;
      end else if (we) begin
        sel_q[i]   <= wr_sel;
        base_q[i]  <= wr_base;
        limit_q[i] <= wr_limit;
        perm_q[i]  <= wr_perm;
      end
    end
  end

  always_comb begin
    rd_sel   = '0;
    rd_base  = '0;
    rd_limit = '0;
    rd_perm  = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (rd_idx == SEGN_W'(i)) begin
        rd_sel   = sel_q[i];
        rd_base  = base_q[i];
        rd_limit = limit_q[i];
        rd_perm  = perm_q[i];
      end
    end
  end
endmodule

// File: rtl/seg_pick.sv
module seg_pick
  import seg_xlat_pkg::*;
#(
  parameter int NSEG = 6
) (
  input  logic [2:0]        kind,
  input  logic              ovr_en,
  input  logic [SEGN_W-1:0] ovr_seg,
  output logic [SEGN_W-1:0] seg
);
  logic [SEGN_W-1:0] dflt;

  always_comb begin
    unique case (kind)
      KIND_FETCH:          dflt = SEG_CODE;
      KIND_PUSH, KIND_POP: dflt = SEG_STACK;
      default:             dflt = SEG_DATA;
    endcase
    if (ovr_en && (ovr_seg < SEGN_W'(NSEG))) seg = ovr_seg;
    else                                     seg = dflt;
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlat_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [2:0]        kind,
  input  logic [AW-1:0]     offset,
  input  logic [1:0]        size_m1,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     limit,
  input  logic [PERM_W-1:0] perm,
  output logic [AW-1:0]     lin_addr,
  output logic [1:0]        fault_code
);
  logic [AW:0] last_byte;
  logic        is_write;
  logic        is_fetch;

  always_comb begin
    last_byte = {1'b0, offset} + (AW+1)'(size_m1);
    is_write  = (kind == KIND_STORE) || (kind == KIND_PUSH);
    is_fetch  = (kind == KIND_FETCH);
    lin_addr  = base + offset;
    fault_code = '0;
    fault_code[FLT_LIMIT] = last_byte > {1'b0, limit};
    fault_code[FLT_PROT]  = (is_write && !perm[PERM_W_BIT]) ||
                            (is_fetch && !perm[PERM_X]);
  end
endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
  import seg_xlat_pkg::*;
#(
  parameter int NSEG = 6,
  parameter int AW   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_en,
  input  logic [2:0]  ld_idx,
  input  logic [15:0] ld_selector,
  input  logic [31:0] ld_base,
  input  logic [31:0] ld_limit,
  input  logic [2:0]  ld_perm,
  input  logic        req_valid,
  input  logic [2:0]  req_kind,
  input  logic        req_ovr_en,
  input  logic [2:0]  req_ovr_seg,
  input  logic [31:0] req_offset,
  input  logic [1:0]  req_size,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [1:0]  rsp_fault_code,
  output logic [31:0] rsp_addr,
  output logic [2:0]  rsp_seg,
  output logic [12:0] rsp_index,
  output logic        rsp_ti,
  output logic [1:0]  rsp_rpl
);
  logic [SEGN_W-1:0] seg_c;
  logic [SEL_W-1:0]  sel_c;
  logic [AW-1:0]     base_c, limit_c, addr_c;
  logic [PERM_W-1:0] perm_c;
  logic [1:0]        code_c;

  seg_pick #(.NSEG(NSEG)) u_pick (
    .kind(req_kind), .ovr_en(req_ovr_en), .ovr_seg(req_ovr_seg), .seg(seg_c)
  );

  seg_regfile #(.NSEG(NSEG), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ld_en), .wr_idx(ld_idx), .wr_sel(ld_selector),
    .wr_base(ld_base), .wr_limit(ld_limit), .wr_perm(ld_perm),
    .rd_idx(seg_c), .rd_sel(sel_c), .rd_base(base_c),
    .rd_limit(limit_c), .rd_perm(perm_c)
  );

  seg_check #(.AW(AW)) u_chk (
    .kind(req_kind), .offset(req_offset), .size_m1(req_size),
    .base(base_c), .limit(limit_c), .perm(perm_c),
    .lin_addr(addr_c), .fault_code(code_c)
  );

  logic             valid_d, fault_d;
  logic [1:0]       code_q;
  logic [AW-1:0]    addr_q;
  logic [SEGN_W-1:0] seg_q;
  logic [SEL_W-1:0] sel_q;

  always_comb begin
    valid_d = req_valid && (code_c == 2'b00);
    fault_d = req_valid && (code_c != 2'b00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      rsp_fault <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      addr_q <= '0;
      seg_q  <= '0;
      sel_q  <= '0;
    end else if (req_valid) begin
      code_q <= code_c;
      addr_q <= addr_c;
      seg_q  <= seg_c;
      sel_q  <= sel_c;
    end
  end

  assign rsp_fault_code = code_q;
  assign rsp_addr       = addr_q[31:0];
  assign rsp_seg        = seg_q;
  assign rsp_index      = sel_q[15:3];
  assign rsp_ti         = sel_q[2];
  assign rsp_rpl        = sel_q[1:0];
endmodule

// File: rtl/seg_xlat_checker.sv
module seg_xlat_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_kind,
  input logic       req_ovr_en,
  input logic       rsp_valid,
  input logic       rsp_fault,
  input logic [1:0] rsp_fault_code,
  input logic [2:0] rsp_seg
);
  AST_VALID_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_fault)); // R9
  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_fault_code != 2'b00); // R9
  AST_CLEAN_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault_code == 2'b00); // R9
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_valid || rsp_fault)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(rsp_valid || rsp_fault)); // R10
  AST_FETCH_CODE_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ovr_en && req_kind == 3'd2) |=> rsp_seg == 3'd0); // R2
  AST_STACK_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ovr_en && (req_kind == 3'd3 || req_kind == 3'd4)) |=> rsp_seg == 3'd2); // R2
endmodule

bind seg_xlat_unit seg_xlat_checker u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_ovr_en(req_ovr_en), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_fault_code(rsp_fault_code), .rsp_seg(rsp_seg)
);

// File: tb/seg_xlat_unit_test.sv
module seg_xlat_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en;
  logic [2:0]  ld_idx;
  logic [15:0] ld_selector;
  logic [31:0] ld_base, ld_limit;
  logic [2:0]  ld_perm;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic        req_ovr_en;
  logic [2:0]  req_ovr_seg;
  logic [31:0] req_offset;
  logic [1:0]  req_size;
  logic        rsp_valid, rsp_fault, rsp_ti;
  logic [1:0]  rsp_fault_code, rsp_rpl;
  logic [31:0] rsp_addr;
  logic [2:0]  rsp_seg;
  logic [12:0] rsp_index;

  always #5 clk = ~clk;

  seg_xlat_unit uut (.*);

  typedef struct {
    logic [1:0]  code;
    logic [31:0] addr;
    logic [2:0]  seg;
    logic [15:0] sel;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;

  logic [15:0] m_sel  [6];
  logic [31:0] m_base [6];
  logic [31:0] m_lim  [6];
  logic [2:0]  m_perm [6];

  function automatic exp_t predict(logic [2:0] k, logic oe, logic [2:0] os,
                                   logic [31:0] off, logic [1:0] sz, string tag);
    exp_t e;
    logic [2:0] s;
    logic [32:0] last;
    logic wr;
    s = (k == 3'd2) ? 3'd0 : ((k == 3'd3 || k == 3'd4) ? 3'd2 : 3'd1);
    if (oe && os < 3'd6) s = os;
    last = {1'b0, off} + 33'(sz);
    wr = (k == 3'd1) || (k == 3'd3);
    e.code[0] = last > {1'b0, m_lim[s]};
    e.code[1] = (wr && !m_perm[s][0]) || (k == 3'd2 && !m_perm[s][2]);
    e.addr = m_base[s] + off;
    e.seg  = s;
    e.sel  = m_sel[s];
    e.tag  = tag;
    return e;
  endfunction

  task automatic quiet();
    ld_en = 1'b0;
    req_valid = 1'b0;
  endtask

  task automatic drive_req(logic [2:0] k, logic oe, logic [2:0] os,
                           logic [31:0] off, logic [1:0] sz, string tag);
    req_valid = 1'b1; req_kind = k; req_ovr_en = oe; req_ovr_seg = os;
    req_offset = off; req_size = sz;
    q.push_back(predict(k, oe, os, off, sz, tag));
  endtask

  task automatic issue(logic [2:0] k, logic oe, logic [2:0] os,
                       logic [31:0] off, logic [1:0] sz, string tag);
    @(negedge clk); quiet();
    drive_req(k, oe, os, off, sz, tag);
  endtask

  task automatic drive_ld(logic [2:0] i, logic [15:0] s, logic [31:0] b,
                          logic [31:0] l, logic [2:0] p);
    ld_en = 1'b1; ld_idx = i; ld_selector = s; ld_base = b; ld_limit = l; ld_perm = p;
    if (i < 3'd6) begin
      m_sel[i] = s; m_base[i] = b; m_lim[i] = l; m_perm[i] = p;
    end
  endtask

  task automatic load(logic [2:0] i, logic [15:0] s, logic [31:0] b,
                      logic [31:0] l, logic [2:0] p);
    @(negedge clk); quiet();
    drive_ld(i, s, b, l, p);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); quiet();
    end
  endtask

  // Monitor: pop expected items as responses appear
  always @(negedge clk) begin
    if (rst_n && (rsp_valid || rsp_fault)) begin
      n_chk++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected response valid=%0b fault=%0b, expected none",
                 rsp_valid, rsp_fault);
      end else begin
        exp_t e;
        logic ok;
        e = q.pop_front();
        ok = (rsp_fault_code == e.code) && (rsp_valid == (e.code == 2'b00)) &&
             (rsp_fault == (e.code != 2'b00)) && (rsp_seg == e.seg) &&
             (rsp_index == e.sel[15:3]) && (rsp_ti == e.sel[2]) && (rsp_rpl == e.sel[1:0]) &&
             (e.code != 2'b00 || rsp_addr == e.addr);
        if (!ok) begin
          n_bad++;
          $display("FAIL %s actual v=%0b f=%0b code=%0d addr=%h seg=%0d idx=%h ti=%0b rpl=%0d expected code=%0d addr=%h seg=%0d idx=%h ti=%0b rpl=%0d",
                   e.tag, rsp_valid, rsp_fault, rsp_fault_code, rsp_addr, rsp_seg,
                   rsp_index, rsp_ti, rsp_rpl, e.code, e.addr, e.seg,
                   e.sel[15:3], e.sel[2], e.sel[1:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, actual hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) begin
      m_sel[i] = '0; m_base[i] = '0; m_lim[i] = 32'hFFFF_FFFF; m_perm[i] = 3'b111;
    end
    rst_n = 1'b0; ld_en = 0; ld_idx = 0; ld_selector = 0; ld_base = 0; ld_limit = 0;
    ld_perm = 0; req_valid = 0; req_kind = 0; req_ovr_en = 0; req_ovr_seg = 0;
    req_offset = 0; req_size = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset outputs v=%0b f=%0b, expected 0 0", rsp_valid, rsp_fault);
    end

    // R1 flat translation after reset, R2 default selection
    issue(3'd0, 0, 0, 32'h0000_1234, 2'd0, "R1 flat load");
    issue(3'd2, 0, 0, 32'hFFFF_FFF0, 2'd3, "R2 fetch->code");
    issue(3'd3, 0, 0, 32'h0000_0100, 2'd3, "R2 push->stack");
    issue(3'd4, 0, 0, 32'h0000_0104, 2'd1, "R2 pop->stack");
    issue(3'd1, 0, 0, 32'h0000_0200, 2'd2, "R2 store->data");
    issue(3'd6, 0, 0, 32'h0000_0300, 2'd0, "R2 kind6->data");
    idle(2);

    // R4 load all six registers, then an out-of-range index
    load(3'd0, 16'h0008, 32'h1000_0000, 32'h0000_FFFF, 3'b110);
    load(3'd1, 16'h0013, 32'h2000_0000, 32'h000F_FFFF, 3'b011);
    load(3'd2, 16'h001F, 32'h3000_0000, 32'h0000_0FFF, 3'b011);
    load(3'd3, 16'h0024, 32'h4000_0000, 32'h0000_00FF, 3'b010);
    load(3'd4, 16'hFFFB, 32'hFFFF_F000, 32'hFFFF_FFFF, 3'b011);
    load(3'd5, 16'h8006, 32'h5000_0000, 32'h0000_0003, 3'b011);
    load(3'd6, 16'hAAAA, 32'hDEAD_0000, 32'h0000_0000, 3'b000);
    load(3'd7, 16'h5555, 32'hBEEF_0000, 32'h0000_0000, 3'b000);

    // R3 R4 R5 R6 override every segment
    for (int s = 0; s < 6; s++)
      issue(3'd0, 1, 3'(s), 32'h0000_0002, 2'd0, "R3 R4 R6 override load");
    issue(3'd2, 1, 3'd6, 32'h0000_0010, 2'd0, "R3 ovr6 ignored");
    issue(3'd3, 1, 3'd7, 32'h0000_0020, 2'd1, "R3 ovr7 ignored");
    issue(3'd0, 1, 3'd4, 32'h0000_2000, 2'd3, "R5 wrap");
    issue(3'd2, 0, 0, 32'h0000_0040, 2'd3, "R5 code base");

    // R7 limit boundaries
    issue(3'd0, 1, 3'd5, 32'h0000_0000, 2'd3, "R7 at limit");
    issue(3'd0, 1, 3'd5, 32'h0000_0001, 2'd3, "R7 past limit");
    issue(3'd0, 1, 3'd5, 32'h0000_0003, 2'd0, "R7 last byte");
    issue(3'd4, 0, 0, 32'h0000_0FFF, 2'd1, "R7 stack edge");
    issue(3'd0, 1, 3'd4, 32'hFFFF_FFFF, 2'd3, "R7 sum carry");
    issue(3'd0, 1, 3'd4, 32'hFFFF_FFFF, 2'd0, "R7 top byte ok");

    // R8 R9 protection
    issue(3'd1, 1, 3'd3, 32'h0000_0010, 2'd0, "R8 store readonly");
    issue(3'd2, 1, 3'd1, 32'h0000_0010, 2'd0, "R8 fetch noexec");
    issue(3'd1, 1, 3'd0, 32'h0000_0010, 2'd0, "R8 store code");
    issue(3'd3, 1, 3'd3, 32'h0000_0100, 2'd0, "R9 limit+prot");
    issue(3'd0, 1, 3'd3, 32'h0000_0010, 2'd0, "R8 read readonly ok");
    idle(2);

    // R11 load and request to the same segment in one cycle
    @(negedge clk); quiet();
    drive_req(3'd0, 0, 0, 32'h0000_0008, 2'd0, "R11 old contents");
    drive_ld(3'd1, 16'h0042, 32'h7000_0000, 32'h0000_0FFF, 3'b011);
    issue(3'd0, 0, 0, 32'h0000_0008, 2'd0, "R11 new contents");
    idle(4);

    n_chk++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R10 pending responses actual %0d expected 0", q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule